// File: doc/BRIEF.md
# FPGA Slave Configuration Sequencer

This block loads a byte-wide configuration image into one of several downstream FPGAs over their slave configuration pins, without processor involvement. One start pulse carries a target index, a start address and a byte count. The sequencer then checks that the chosen target has a configuration space and, if it does, runs a fixed program. It raises the target's optional enable line and lets go of the target's INIT line. It pulses the active-low PROGRAM line and waits for INIT to rise. It then streams every image byte in order from a valid/ready source, writing each byte to the FPGA with a one-cycle strobe. Finally it waits for DONE.

Each waiting step has its own timeout. The DONE window is a fixed multiple (ten by default) of the INIT window. The load ends with a single-cycle completion flag and a 2-bit result code. Until a target's first load, the sequencer holds that target's INIT line low, which keeps the FPGA from starting its own power-on configuration. INIT and DONE are brought into the clock domain through two-stage synchronizers before the sequencer looks at them.

Top module: `fpga_cfg_seq`

## Requirements
- R1: After reset, busy_o, fin_o, every tgt_en_o bit and every wr_o bit are 0; every prog_n_o bit and every init_oe_o bit are 1 (INIT held low on all targets).
- R2: A start accepted while idle on a target whose present_i bit is 0 gives fin_o one cycle later with result_o = 1. busy_o stays 0 and no pin of any target changes.
- R3: On a present target whose has_en_i bit is 1, tgt_en_o for that target is 1 in exactly the cycles where busy_o is 1 and returns to 0 with fin_o, whatever the result. Without has_en_i it stays 0.
- R4: An accepted start on a present target clears that target's init_oe_o bit (INIT released) in the next cycle, and the bit stays 0 from then on.
- R5: prog_n_o of the selected target goes low in the cycle after the accepted start and stays low for exactly PROG_CLKS cycles, then returns high.
- R6: After PROGRAM returns high, the sequencer waits for the synchronized INIT. If INIT is not seen within INIT_TMO cycles, the load ends with result_o = 2, and fin_o rises exactly PROG_CLKS + INIT_TMO cycles after the start edge.
- R7: With INIT seen, bytes are fetched in order from rd_addr_o = start address + n for n = 0 .. count-1 (address modulo 2^AW). rd_ready_o is 1 only in the data phase. For each cycle with rd_valid_i and rd_ready_o both 1, wr_o of the selected target pulses for one cycle in the next cycle, with that byte on wr_data_o.
- R8: After the last byte, the sequencer waits for the synchronized DONE: if it is seen the result is 0, otherwise result_o = 3 with fin_o rising exactly INIT_TMO*DONE_MULT cycles after the last strobe.
- R9: A count of 0 skips the data phase: no strobe is issued and the sequencer goes straight from INIT to the DONE wait.
- R10: fin_o is a single-cycle pulse, exactly one per accepted start. busy_o covers the whole sequence, and a start pulse while busy_o is 1 is ignored.
- R11: Pins of targets other than the selected one (prog_n_o, init_oe_o, tgt_en_o, wr_o) do not change during a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle load request, taken only when idle |
| tgt_i | input | SEL_W | Target index for the load |
| base_i | input | AW | Image start address |
| len_i | input | CW | Image size in bytes |
| present_i | input | N_TGT | Per target: configuration space exists |
| has_en_i | input | N_TGT | Per target: target has an enable line |
| rd_addr_o | output | AW | Address of the byte being fetched |
| rd_ready_o | output | 1 | Sequencer accepts a byte this cycle |
| rd_valid_i | input | 1 | Source byte on rd_data_i is valid |
| rd_data_i | input | DW | Source byte |
| tgt_en_o | output | N_TGT | Per target enable line |
| prog_n_o | output | N_TGT | Per target PROGRAM, active low |
| init_oe_o | output | N_TGT | Per target INIT open-drain pull-down enable (1 = held low) |
| wr_o | output | N_TGT | Per target configuration write strobe |
| wr_data_o | output | DW | Configuration byte |
| init_i | input | N_TGT | Per target INIT level, asynchronous |
| done_i | input | N_TGT | Per target DONE level, asynchronous |
| busy_o | output | 1 | Load in progress |
| fin_o | output | 1 | One-cycle completion pulse |
| result_o | output | 2 | 0 success, 1 no configuration space, 2 no INIT, 3 no DONE |

## Verification
A wrong state register shows at the pins almost at once. An early or late exit from the PROGRAM phase changes the low width of prog_n_o, and that width is counted cycle by cycle. A misrouted target select moves pins on the wrong target within one cycle of the start. A wrong byte counter shows as a wrong address, a wrong data byte or a wrong strobe count before fin_o. A wrong timeout limit shows as a completion edge that is early or late by a measurable number of cycles.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_PROG  = 3'd1,
      ST_WINIT = 3'd2,
      ST_DATA  = 3'd3,
      ST_WDONE = 3'd4
   } seq_st_e;

   typedef enum logic [1:0] {
      RES_OK     = 2'd0,
      RES_NOCFG  = 2'd1,
      RES_NOINIT = 2'd2,
      RES_NODONE = 2'd3
   } seq_res_e;
endpackage

// File: rtl/cfg_sync2.sv
module cfg_sync2 #(
   parameter int W = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   if (W < 1) begin : g_bad_w
      $error("cfg_sync2: W must be at least 1");
   end

   for (genvar b = 0; b < W; b++) begin : g_bit
      logic meta_q, stab_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            meta_q <= 1'b0;
            stab_q <= 1'b0;
         end else begin
            meta_q <= d_i[b];
            stab_q <= meta_q;
         end
      end
      assign q_o[b] = stab_q;
   end
endmodule

// File: rtl/cfg_wait_timer.sv
module cfg_wait_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic         inc_i,
   input  logic [W-1:0] limit_i,
   output logic         hit_o
);
   if (W < 1) begin : g_bad_w
      $error("cfg_wait_timer: W must be at least 1");
   end

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (clr_i) cnt_q <= '0;
      else if (inc_i) cnt_q <= cnt_q + 1'b1;
   end

   // hit on the last cycle of a window of limit_i cycles
   assign hit_o = (cnt_q == (limit_i - 1'b1));
endmodule

// File: rtl/fpga_cfg_seq.sv
module fpga_cfg_seq
   import cfg_seq_pkg::*;
#(
   parameter int N_TGT     = 2,
   parameter int AW        = 24,
   parameter int CW        = 24,
   parameter int DW        = 8,
   parameter int PROG_CLKS = 20,
   parameter int INIT_TMO  = 1000000,
   parameter int DONE_MULT = 10,
   localparam int SEL_W    = (N_TGT > 1) ? $clog2(N_TGT) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [SEL_W-1:0] tgt_i,
   input  logic [AW-1:0]    base_i,
   input  logic [CW-1:0]    len_i,
   input  logic [N_TGT-1:0] present_i,
   input  logic [N_TGT-1:0] has_en_i,
   output logic [AW-1:0]    rd_addr_o,
   output logic             rd_ready_o,
   input  logic             rd_valid_i,
   input  logic [DW-1:0]    rd_data_i,
   output logic [N_TGT-1:0] tgt_en_o,
   output logic [N_TGT-1:0] prog_n_o,
   output logic [N_TGT-1:0] init_oe_o,
   output logic [N_TGT-1:0] wr_o,
   output logic [DW-1:0]    wr_data_o,
   input  logic [N_TGT-1:0] init_i,
   input  logic [N_TGT-1:0] done_i,
   output logic             busy_o,
   output logic             fin_o,
   output logic [1:0]       result_o
);
   localparam int DONE_TMO = INIT_TMO * DONE_MULT;
   localparam int MAX_LIM  = (DONE_TMO > PROG_CLKS) ? DONE_TMO : PROG_CLKS;
   localparam int TMR_W    = $clog2(MAX_LIM + 1);

   if (N_TGT < 1)     begin : g_bad_ntgt  $error("N_TGT must be at least 1");  end
   if (PROG_CLKS < 1) begin : g_bad_prog  $error("PROG_CLKS must be at least 1"); end
   if (INIT_TMO < 1)  begin : g_bad_init  $error("INIT_TMO must be at least 1"); end
   if (DONE_MULT < 1) begin : g_bad_mult  $error("DONE_MULT must be at least 1"); end
   if (DW < 1)        begin : g_bad_dw    $error("DW must be at least 1"); end
   if (CW > AW)       begin : g_bad_cw    $error("CW must not exceed AW"); end

   seq_st_e          st_q, st_d;
   seq_res_e         res_d;
   logic             fin_d;
   logic [SEL_W-1:0] sel_q;
   logic [AW-1:0]    base_q;
   logic [AW-1:0]    off_q;
   logic [CW-1:0]    left_q;
   logic [N_TGT-1:0] init_s, done_s;
   logic             hit, tmr_clr, tmr_inc;
   logic [TMR_W-1:0] limit;
   logic             hs, acc_ok, prog_end;

   // ---------------- input synchronizers ----------------
   cfg_sync2 #(.W(N_TGT)) u_init_sync (.clk(clk), .rst_n(rst_n), .d_i(init_i), .q_o(init_s));
   cfg_sync2 #(.W(N_TGT)) u_done_sync (.clk(clk), .rst_n(rst_n), .d_i(done_i), .q_o(done_s));

   // ---------------- shared phase timer ----------------
   always_comb begin
      unique case (st_q)
         ST_PROG:  limit = TMR_W'(PROG_CLKS);
         ST_WINIT: limit = TMR_W'(INIT_TMO);
         default:  limit = TMR_W'(DONE_TMO);
      endcase
   end

   assign tmr_clr = (st_d != st_q);
   assign tmr_inc = (st_q == ST_PROG) || (st_q == ST_WINIT) || (st_q == ST_WDONE);

   cfg_wait_timer #(.W(TMR_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .clr_i(tmr_clr), .inc_i(tmr_inc),
      .limit_i(limit), .hit_o(hit)
   );

   // ---------------- sequencing ----------------
   assign hs       = (st_q == ST_DATA) && rd_valid_i;
   assign acc_ok   = (st_q == ST_IDLE) && start_i && present_i[tgt_i];
   assign prog_end = (st_q == ST_PROG) && hit;

   always_comb begin
      st_d  = st_q;
      res_d = RES_OK;
      fin_d = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (start_i) begin
               if (present_i[tgt_i]) st_d = ST_PROG;
               else begin
                  fin_d = 1'b1;
                  res_d = RES_NOCFG;
               end
            end
         end
         ST_PROG: if (hit) st_d = ST_WINIT;
         ST_WINIT: begin
            if (init_s[sel_q]) st_d = (left_q == '0) ? ST_WDONE : ST_DATA;
            else if (hit) begin
               st_d  = ST_IDLE;
               fin_d = 1'b1;
               res_d = RES_NOINIT;
            end
         end
         ST_DATA: if (hs && (left_q == CW'(1))) st_d = ST_WDONE;
         ST_WDONE: begin
            if (done_s[sel_q]) begin
               st_d  = ST_IDLE;
               fin_d = 1'b1;
               res_d = RES_OK;
            end else if (hit) begin
               st_d  = ST_IDLE;
               fin_d = 1'b1;
               res_d = RES_NODONE;
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         sel_q    <= '0;
         base_q   <= '0;
         off_q    <= '0;
         left_q   <= '0;
         fin_o    <= 1'b0;
         result_o <= RES_OK;
      end else begin
         st_q  <= st_d;
         fin_o <= fin_d;
         if (fin_d) result_o <= res_d;
         if (acc_ok) begin
            sel_q  <= tgt_i;
            base_q <= base_i;
            off_q  <= '0;
            left_q <= len_i;
         end else if (hs) begin
            off_q  <= off_q + 1'b1;
            left_q <= left_q - 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  wr_data_o <= '0;
      else if (hs) wr_data_o <= rd_data_i;
   end

   assign rd_addr_o  = base_q + off_q;
   assign rd_ready_o = (st_q == ST_DATA);
   assign busy_o     = (st_q != ST_IDLE);

   // ---------------- per-target pin drivers ----------------
   for (genvar i = 0; i < N_TGT; i++) begin : g_tgt
      localparam logic [SEL_W-1:0] IDX = SEL_W'(i);
      logic pick_new, pick_cur;
      assign pick_new = acc_ok && (tgt_i == IDX);
      assign pick_cur = (sel_q == IDX);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prog_n_o[i]  <= 1'b1;
            init_oe_o[i] <= 1'b1;
            tgt_en_o[i]  <= 1'b0;
            wr_o[i]      <= 1'b0;
         end else begin
            wr_o[i] <= hs && pick_cur;
            if (pick_new) begin
               prog_n_o[i]  <= 1'b0;
               init_oe_o[i] <= 1'b0;
               tgt_en_o[i]  <= has_en_i[i];
            end else begin
               if (prog_end && pick_cur) prog_n_o[i] <= 1'b1;
               if (fin_d)                tgt_en_o[i] <= 1'b0;
            end
         end
      end
   end
endmodule

// File: rtl/fpga_cfg_seq_chk.sv
module fpga_cfg_seq_chk #(
   parameter int N_TGT     = 2,
   parameter int SEL_W     = 1,
   parameter int PROG_CLKS = 20
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic [SEL_W-1:0] tgt_i,
   input logic [N_TGT-1:0] present_i,
   input logic             rd_ready_o,
   input logic             rd_valid_i,
   input logic [N_TGT-1:0] tgt_en_o,
   input logic [N_TGT-1:0] prog_n_o,
   input logic [N_TGT-1:0] init_oe_o,
   input logic [N_TGT-1:0] wr_o,
   input logic             busy_o,
   input logic             fin_o,
   input logic [1:0]       result_o
);
   localparam int LW = $clog2(PROG_CLKS + 2) + 1;
   localparam logic [LW-1:0] LMAX = {LW{1'b1}};

   logic [LW-1:0] low_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  low_cnt <= '0;
      else if (prog_n_o != '1)     low_cnt <= (low_cnt == LMAX) ? low_cnt : low_cnt + 1'b1;
      else                         low_cnt <= '0;
   end

   // R10
   a_r10_fin_single: assert property (@(posedge clk) disable iff (!rst_n)
      fin_o |=> !fin_o);
   // R7
   a_r7_ready_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
      rd_ready_o |-> busy_o);
   // R7
   a_r7_wr_after_hs: assert property (@(posedge clk) disable iff (!rst_n)
      (|wr_o) |-> $past(rd_valid_i && rd_ready_o));
   // R11
   a_r11_wr_one_tgt: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_o));
   // R2
   a_r2_nocfg: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && start_i && !present_i[tgt_i]) |=> (fin_o && result_o == 2'd1 && !busy_o));
   // R3
   a_r3_en_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (tgt_en_o == '0));
   // R4
   a_r4_init_stays: assert property (@(posedge clk) disable iff (!rst_n)
      (init_oe_o & ~$past(init_oe_o)) == '0);
   // R5
   a_r5_prog_width: assert property (@(posedge clk) disable iff (!rst_n)
      ((prog_n_o == '1) && (low_cnt != '0)) |-> (low_cnt == LW'(PROG_CLKS)));
   // R5
   a_r5_prog_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_n_o != '1) |-> busy_o);
endmodule

bind fpga_cfg_seq fpga_cfg_seq_chk #(
   .N_TGT(N_TGT), .SEL_W(SEL_W), .PROG_CLKS(PROG_CLKS)
) chk_i (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .tgt_i(tgt_i), .present_i(present_i),
   .rd_ready_o(rd_ready_o), .rd_valid_i(rd_valid_i), .tgt_en_o(tgt_en_o),
   .prog_n_o(prog_n_o), .init_oe_o(init_oe_o), .wr_o(wr_o), .busy_o(busy_o),
   .fin_o(fin_o), .result_o(result_o)
);

// File: tb/fpga_cfg_seq_tb.sv
module fpga_cfg_seq_tb_top;
   localparam int N_TGT = 2;
   localparam int AW    = 16;
   localparam int CW    = 12;
   localparam int DW    = 8;
   localparam int PCLK  = 20;
   localparam int ITMO  = 50;
   localparam int DMUL  = 10;
   localparam int DTMO  = ITMO * DMUL;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start_i = 1'b0;
   logic [0:0]       tgt_i = '0;
   logic [AW-1:0]    base_i = '0;
   logic [CW-1:0]    len_i = '0;
   logic [N_TGT-1:0] present_i = '0;
   logic [N_TGT-1:0] has_en_i = '0;
   logic [AW-1:0]    rd_addr_o;
   logic             rd_ready_o;
   logic             rd_valid_i = 1'b0;
   logic [DW-1:0]    rd_data_i;
   logic [N_TGT-1:0] tgt_en_o, prog_n_o, init_oe_o, wr_o;
   logic [DW-1:0]    wr_data_o;
   logic [N_TGT-1:0] init_i = '0;
   logic [N_TGT-1:0] done_i = '0;
   logic             busy_o, fin_o;
   logic [1:0]       result_o;

   always #2.5 clk = ~clk;

   fpga_cfg_seq #(
      .N_TGT(N_TGT), .AW(AW), .CW(CW), .DW(DW),
      .PROG_CLKS(PCLK), .INIT_TMO(ITMO), .DONE_MULT(DMUL)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .tgt_i(tgt_i), .base_i(base_i),
      .len_i(len_i), .present_i(present_i), .has_en_i(has_en_i), .rd_addr_o(rd_addr_o),
      .rd_ready_o(rd_ready_o), .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i),
      .tgt_en_o(tgt_en_o), .prog_n_o(prog_n_o), .init_oe_o(init_oe_o), .wr_o(wr_o),
      .wr_data_o(wr_data_o), .init_i(init_i), .done_i(done_i), .busy_o(busy_o),
      .fin_o(fin_o), .result_o(result_o)
   );

   function automatic logic [7:0] img(input logic [15:0] a);
      logic [15:0] m;
      m = a * 16'd37 + (a >> 8);
      return m[7:0] ^ 8'h5A;
   endfunction

   function automatic int exp_res(input bit pres, input int idly, input int ddly);
      if (!pres)     return 1;
      if (idly < 0)  return 2;
      if (ddly < 0)  return 3;
      return 0;
   endfunction

   assign rd_data_i = img(rd_addr_o);

   int n_total = 0, n_bad = 0;
   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_total++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // ---------------- model / monitor state ----------------
   bit          mon_on = 0;
   int          m_tgt = 0, m_len = 0, m_idly = 0, m_ddly = 0;
   bit          m_hasen = 0;
   logic [15:0] m_base = '0;
   logic [N_TGT-1:0] oth_init_snap = '1;
   int  n_busy, n_plow, n_wr, n_dbad, n_enbad, n_othbad, n_fin, got_res, since_wr, gap_fin;
   int  init_cd, done_cd;
   bit  init_arm, prev_plow;
   int  cyc = 0;

   always @(negedge clk) begin
      cyc++;
      if (mon_on) begin
         rd_valid_i = (($urandom % 4) != 0);
         if (busy_o) n_busy++;
         if (!prog_n_o[m_tgt]) n_plow++;
         if (prog_n_o[m_tgt] && prev_plow) begin init_arm = 1; init_cd = 0; end
         prev_plow = !prog_n_o[m_tgt];
         if (init_arm) begin
            if (m_idly >= 0 && init_cd >= m_idly) init_i[m_tgt] = 1'b1;
            init_cd++;
         end
         if (wr_o[m_tgt]) begin
            if (wr_data_o !== img(m_base + 16'(n_wr))) n_dbad++;
            n_wr++;
            since_wr = 0;
         end else since_wr++;
         if (init_i[m_tgt] && n_wr == m_len) begin
            if (m_ddly >= 0 && done_cd >= m_ddly) done_i[m_tgt] = 1'b1;
            done_cd++;
         end
         if (tgt_en_o[m_tgt] !== (busy_o && m_hasen)) n_enbad++;
         for (int k = 0; k < N_TGT; k++) begin
            if (k != m_tgt) begin
               if (prog_n_o[k] !== 1'b1 || tgt_en_o[k] !== 1'b0 || wr_o[k] !== 1'b0 ||
                   init_oe_o[k] !== oth_init_snap[k]) n_othbad++;
            end
         end
         if (fin_o) begin
            n_fin++;
            got_res = result_o;
            gap_fin = since_wr;
         end
      end
      if (cyc > 150000) begin
         n_total++; n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         $display("test done: total=%0d bad=%0d", n_total, n_bad);
         $finish;
      end
   end

   task automatic run_load(input int tgt, input int base, input int len, input int idly,
                           input int ddly, input bit pres, input bit hasen, input bit poke);
      int er, wait_n, exp_wr;
      logic [N_TGT-1:0] init_before;
      @(negedge clk);
      present_i        = N_TGT'($urandom);
      has_en_i         = N_TGT'($urandom);
      present_i[tgt]   = pres;
      has_en_i[tgt]    = hasen;
      init_i[tgt]      = 1'b0;
      done_i[tgt]      = 1'b0;
      m_tgt = tgt; m_len = len; m_idly = idly; m_ddly = ddly; m_hasen = hasen;
      m_base = 16'(base);
      oth_init_snap = init_oe_o;
      init_before   = init_oe_o;
      n_busy = 0; n_plow = 0; n_wr = 0; n_dbad = 0; n_enbad = 0; n_othbad = 0; n_fin = 0;
      got_res = -1; since_wr = 0; gap_fin = -1; init_cd = 0; done_cd = 0;
      init_arm = 0; prev_plow = 0;
      start_i = 1'b1; tgt_i = 1'(tgt); base_i = AW'(base); len_i = CW'(len);
      mon_on = 1;
      @(negedge clk);
      start_i = 1'b0;
      if (poke) begin
         repeat (5) @(negedge clk);
         start_i = 1'b1; tgt_i = 1'(1 - tgt); len_i = CW'(3);
         @(negedge clk);
         start_i = 1'b0;
      end
      wait_n = 0;
      while (n_fin == 0 && wait_n < 5000) begin @(negedge clk); wait_n++; end
      repeat (4) @(negedge clk);
      mon_on = 0;
      rd_valid_i = 1'b0;
      er = exp_res(pres, idly, ddly);
      exp_wr = (er == 0 || er == 3) ? len : 0;
      chk(got_res == er, "R2/R6/R8 result code", got_res, er);
      chk(n_fin == 1, "R10 one fin per start", n_fin, 1);
      chk(n_wr == exp_wr, (len == 0) ? "R9 strobe count" : "R7 strobe count", n_wr, exp_wr);
      chk(n_dbad == 0, "R7 byte data/order", n_dbad, 0);
      chk(n_enbad == 0, "R3 enable follows busy", n_enbad, 0);
      chk(n_othbad == 0, "R11 other target pins", n_othbad, 0);
      if (pres) begin
         chk(n_plow == PCLK, "R5 PROGRAM low width", n_plow, PCLK);
         chk(init_oe_o[tgt] == 1'b0, "R4 INIT released", int'(init_oe_o[tgt]), 0);
      end else begin
         chk(n_plow == 0 && n_busy == 0, "R2 no pins no busy", n_plow + n_busy, 0);
         chk(init_oe_o == init_before, "R2 INIT untouched", int'(init_oe_o), int'(init_before));
      end
      if (er == 2) chk(n_busy == PCLK + ITMO, "R6 INIT timeout latency", n_busy, PCLK + ITMO);
      if (er == 3 && len > 0) chk(gap_fin == DTMO, "R8 DONE timeout latency", gap_fin, DTMO);
   endtask

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(busy_o == 0 && fin_o == 0, "R1 busy/fin after reset", int'({busy_o, fin_o}), 0);
      chk(prog_n_o == '1 && init_oe_o == '1, "R1 PROGRAM high, INIT held",
          int'({prog_n_o, init_oe_o}), 15);
      chk(tgt_en_o == '0 && wr_o == '0, "R1 enables and strobes low", int'({tgt_en_o, wr_o}), 0);
      // directed corner cases
      run_load(0, 16'h0100, 12, 3, 2, 1, 1, 0);   // success with enable
      run_load(1, 16'h0000, 5, 0, 0, 0, 1, 0);    // R2 no config space
      run_load(1, 16'hFFFC, 9, 5, 1, 1, 0, 0);    // address wrap, mezz target, no enable
      run_load(0, 16'h2000, 4, -1, 0, 1, 1, 0);   // R6 INIT timeout
      run_load(1, 16'h3000, 6, 2, -1, 1, 1, 0);   // R8 DONE timeout
      run_load(0, 16'h4000, 0, 1, 0, 1, 1, 0);    // R9 zero length
      run_load(0, 16'h5000, 20, 4, 3, 1, 0, 1);   // R10 start while busy
      // random loads
      for (int k = 0; k < 10; k++) begin
         run_load(int'($urandom % 2), int'($urandom % 65536), int'($urandom % 33),
                  (($urandom % 5) == 0) ? -1 : int'($urandom % 20),
                  (($urandom % 5) == 0) ? -1 : int'($urandom % 6),
                  (($urandom % 6) != 0), bit'($urandom % 2), bit'($urandom % 3 == 0));
      end
      $display("test done: total=%0d bad=%0d", n_total, n_bad);
      $finish;
   end
endmodule